// File: doc/BRIEF.md
# Vector Immediate Logic and Element Shuffle Unit

This unit computes a new value for a 128-bit vector register from three operands: a source vector, the destination's current (old) vector, and an 8-bit immediate. The operation arrives already decoded as a 4-bit code, together with a valid strobe. The unit supports the following operations:

- bytewise AND, OR, XOR and NOR against the immediate;
- three bit-merge and select forms that mix the source, the old destination and the immediate;
- an element shuffle at byte, halfword or word size, where 2-bit selectors packed in the immediate choose an element within each group of four.

The result is registered. It leaves on a valid/ready stream one cycle after the request is accepted.

The input side accepts a request when `in_valid` and `in_ready` are both high on a rising clock edge. `in_ready` is high whenever the output register is empty, or when its content is being taken in the same cycle (`out_ready` high). This gives a one-entry pipeline that sustains one operation per cycle with no bubbles.

While `out_valid` is high and `out_ready` is low, the output holds its data and no new request is accepted. An operation code the unit does not define is still consumed. It leaves the held data untouched and pulses a plain `out_illegal` flag instead of producing a result.

Top module: `simd_imm_unit`

## Requirements
- R1: After reset, `out_valid` and `out_illegal` are 0, `out_data` is all zeros and `in_ready` is 1.
- R2: Codes 0 (AND), 1 (OR), 2 (NOR = inverted OR) and 3 (XOR) combine every byte of `in_src` independently with `in_imm`.
- R3: Code 4 (merge where set) gives, per byte, `(src & imm) | (dst & ~imm)`.
- R4: Code 5 (merge where clear) gives, per byte, `(src & ~imm) | (dst & imm)`.
- R5: Code 6 (select) uses the old destination as the selector and gives, per byte, `(src & ~dst) | (dst & imm)`.
- R6: Codes 7 (byte elements) and 8 (halfword elements) shuffle within groups of four. Result element i is taken from source element `4*(i/4) + imm[2*(i%4)+1 : 2*(i%4)]`, where element 0 occupies the least significant bits.
- R7: Code 9 shuffles words as a single group: result word i is taken from source word `imm[2i+1:2i]`.
- R8: A legal request accepted on one rising edge appears on `out_data` with `out_valid` high and `out_illegal` low right after the next rising edge.
- R9: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. A result taken with no new request accepted clears `out_valid`.
- R10: An accepted request with code 10 to 15 leaves `out_data` unchanged. For the following cycle it raises `out_illegal` and drives `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can accept a request this cycle |
| in_op | input | 4 | Decoded operation code |
| in_src | input | 128 | Source vector |
| in_dst | input | 128 | Old destination vector |
| in_imm | input | 8 | Immediate / packed shuffle selectors |
| out_valid | output | 1 | Result present on `out_data` |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 128 | New destination vector |
| out_illegal | output | 1 | One-cycle pulse after an undefined code was consumed |

## Verification
The bound checker covers the stream rules on every cycle:
- stall holding and the ready relation;
- the valid and illegal flags one cycle after each acceptance;
- data staying put after an undefined code;
- the AND result against the sampled operands.

The correctness of the merge, select and shuffle results can be shown only by the bench's scenarios. Those scenarios drive varied immediates, including the identity and reversal selector patterns, through a behavioural model. The same applies to the reset state and to the interplay of back-pressure with streaming requests.

// File: rtl/simd_imm_pkg.sv
package simd_imm_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ANDI   = 4'd0,
    OP_ORI    = 4'd1,
    OP_NORI   = 4'd2,
    OP_XORI   = 4'd3,
    OP_MRG_NZ = 4'd4,
    OP_MRG_Z  = 4'd5,
    OP_SEL    = 4'd6,
    OP_SHUF_B = 4'd7,
    OP_SHUF_H = 4'd8,
    OP_SHUF_W = 4'd9
  } simd_op_e;

  localparam logic [OP_W-1:0] OP_LAST = OP_SHUF_W;

  function automatic logic op_legal(input logic [OP_W-1:0] code);
    return code <= OP_LAST;
  endfunction

  function automatic logic op_is_bytewise(input logic [OP_W-1:0] code);
    return code <= OP_SEL;
  endfunction

endpackage

// File: rtl/simd_bytelogic.sv
module simd_bytelogic
  import simd_imm_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int IMM_W = 8
) (
  input  logic [OP_W-1:0]  op,
  input  logic [VEC_W-1:0] src,
  input  logic [VEC_W-1:0] dst,
  input  logic [IMM_W-1:0] imm,
  output logic [VEC_W-1:0] res
);
  localparam int LANES = VEC_W / IMM_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [IMM_W-1:0] s, d, r;
    assign s = src[l*IMM_W +: IMM_W];
    assign d = dst[l*IMM_W +: IMM_W];

    always_comb begin
      case (op)
        OP_ANDI:   r = s & imm;
        OP_ORI:    r = s | imm;
        OP_NORI:   r = ~(s | imm);
        OP_XORI:   r = s ^ imm;
        OP_MRG_NZ: r = (s & imm) | (d & ~imm);
        OP_MRG_Z:  r = (s & ~imm) | (d & imm);
        OP_SEL:    r = (s & ~d) | (d & imm);
        default:   r = '0;
      endcase
    end

    assign res[l*IMM_W +: IMM_W] = r;
  end

endmodule

// File: rtl/simd_shuffle.sv
module simd_shuffle #(
  parameter int VEC_W  = 128,
  parameter int ELEM_W = 8,
  parameter int IMM_W  = 8
) (
  input  logic [VEC_W-1:0] src,
  input  logic [IMM_W-1:0] imm,
  output logic [VEC_W-1:0] res
);
  localparam int NELEM = VEC_W / ELEM_W;
  localparam int GROUP = 4;
  localparam int SEL_W = IMM_W / GROUP;

  logic [ELEM_W-1:0] elem [NELEM];

  for (genvar e = 0; e < NELEM; e++) begin : g_unpack
    assign elem[e] = src[e*ELEM_W +: ELEM_W];
  end

  for (genvar i = 0; i < NELEM; i++) begin : g_pick
    localparam int BASE = (i / GROUP) * GROUP;
    localparam int POS  = i % GROUP;
    logic [SEL_W-1:0] k;
    assign k = imm[POS*SEL_W +: SEL_W];
    assign res[i*ELEM_W +: ELEM_W] = elem[BASE + int'(k)];
  end

endmodule

// File: rtl/simd_imm_unit.sv
module simd_imm_unit
  import simd_imm_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int IMM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [3:0]       in_op,
  input  logic [VEC_W-1:0] in_src,
  input  logic [VEC_W-1:0] in_dst,
  input  logic [IMM_W-1:0] in_imm,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_data,
  output logic             out_illegal
);
  localparam int N_SHUF = 3;
  localparam int SHUF_BASE_W = 8;

  logic [VEC_W-1:0] logic_res;
  logic [VEC_W-1:0] shuf_res [N_SHUF];
  logic [VEC_W-1:0] next_res;
  logic [VEC_W-1:0] data_q;
  logic             valid_q, ill_q, accept;

  simd_bytelogic #(.VEC_W(VEC_W), .IMM_W(IMM_W)) u_logic (
    .op(in_op), .src(in_src), .dst(in_dst), .imm(in_imm), .res(logic_res)
  );

  for (genvar g = 0; g < N_SHUF; g++) begin : g_shuf
    simd_shuffle #(.VEC_W(VEC_W), .ELEM_W(SHUF_BASE_W << g), .IMM_W(IMM_W)) u_shuf (
      .src(in_src), .imm(in_imm), .res(shuf_res[g])
    );
  end

  always_comb begin
    case (in_op)
      OP_SHUF_B: next_res = shuf_res[0];
      OP_SHUF_H: next_res = shuf_res[1];
      OP_SHUF_W: next_res = shuf_res[2];
      default:   next_res = op_is_bytewise(in_op) ? logic_res : data_q;
    endcase
  end

  assign in_ready = !valid_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      ill_q   <= 1'b0;
    end else if (accept) begin
      if (op_legal(in_op)) begin
        data_q  <= next_res;
        valid_q <= 1'b1;
        ill_q   <= 1'b0;
      end else begin
        valid_q <= 1'b0;
        ill_q   <= 1'b1;
      end
    end else begin
      ill_q <= 1'b0;
      if (out_ready) valid_q <= 1'b0;
    end
  end

  assign out_data    = data_q;
  assign out_valid   = valid_q;
  assign out_illegal = ill_q;

endmodule

// File: rtl/simd_imm_chk.sv
module simd_imm_chk #(
  parameter int VEC_W = 128,
  parameter int IMM_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [3:0]       in_op,
  input logic [VEC_W-1:0] in_src,
  input logic [IMM_W-1:0] in_imm,
  input logic             out_valid,
  input logic             out_ready,
  input logic [VEC_W-1:0] out_data,
  input logic             out_illegal
);
  localparam int LANES = VEC_W / IMM_W;

  // R9
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R9
  no_accept_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R9
  drain_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  // R8
  legal_accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_op <= 4'd9) |=> out_valid && !out_illegal);

  // R10
  illegal_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_op > 4'd9) |=> out_illegal && !out_valid && $stable(out_data));

  // R2
  andi_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_op == 4'd0) |=> out_data == ($past(in_src) & {LANES{$past(in_imm)}}));

endmodule

bind simd_imm_unit simd_imm_chk #(.VEC_W(VEC_W), .IMM_W(IMM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
  .in_src(in_src), .in_imm(in_imm), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_illegal(out_illegal)
);

// File: tb/simd_imm_unit_tb.sv
module simd_imm_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, out_ready = 1'b1;
  logic [3:0]   in_op = '0;
  logic [127:0] in_src = '0, in_dst = '0;
  logic [7:0]   in_imm = '0;
  logic         in_ready, out_valid, out_illegal;
  logic [127:0] out_data;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural reference state
  logic [127:0] m_data = '0;
  logic         m_valid = 1'b0, m_ill = 1'b0;

  always #2 clk = ~clk;

  simd_imm_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_src(in_src), .in_dst(in_dst), .in_imm(in_imm), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_illegal(out_illegal)
  );

  function automatic logic [127:0] ref_op(int op, logic [127:0] s, logic [127:0] d, logic [7:0] m);
    logic [127:0] r = '0;
    if (op <= 6) begin
      for (int b = 0; b < 16; b++) begin
        logic [7:0] sb = s[b*8 +: 8];
        logic [7:0] db = d[b*8 +: 8];
        logic [7:0] rb = '0;
        case (op)
          0: rb = sb & m;
          1: rb = sb | m;
          2: rb = ~(sb | m);
          3: rb = sb ^ m;
          4: rb = (sb & m) | (db & ~m);
          5: rb = (sb & ~m) | (db & m);
          default: rb = (sb & ~db) | (db & m);
        endcase
        r[b*8 +: 8] = rb;
      end
    end else begin
      int esz = (op == 7) ? 8 : (op == 8) ? 16 : 32;
      for (int i = 0; i < 128 / esz; i++) begin
        int g = (i / 4) * 4;
        int k = (m >> (2 * (i % 4))) & 3;
        for (int b = 0; b < esz; b++) r[i*esz + b] = s[(g + k)*esz + b];
      end
    end
    return r;
  endfunction

  function automatic string tag_of(int op);
    if (op <= 3) return "R2";
    if (op == 4) return "R3";
    if (op == 5) return "R4";
    if (op == 6) return "R5";
    if (op <= 8) return "R6";
    if (op == 9) return "R7";
    return "R10";
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_data <= '0; m_valid <= 1'b0; m_ill <= 1'b0;
    end else if (in_valid && (!m_valid || out_ready)) begin
      if (in_op <= 4'd9) begin
        m_data <= ref_op(int'(in_op), in_src, in_dst, in_imm);
        m_valid <= 1'b1; m_ill <= 1'b0;
      end else begin
        m_valid <= 1'b0; m_ill <= 1'b1;
      end
    end else begin
      m_ill <= 1'b0;
      if (out_ready) m_valid <= 1'b0;
    end
  end

  task automatic check1(string what, logic [127:0] act, logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check1("out_data", out_data, m_data);
      check1("out_valid", {127'd0, out_valid}, {127'd0, m_valid});
      check1("out_illegal", {127'd0, out_illegal}, {127'd0, m_ill});
      check1("in_ready R9", {127'd0, in_ready}, {127'd0, (!m_valid || out_ready)});
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  logic [127:0] seed = 128'h0123456789abcdef_fedcba9876543210;

  function automatic logic [127:0] mix(logic [127:0] x);
    return {x[94:0], x[127:95]} ^ (x * 128'd6364136223846793005) ^ 128'h9e3779b97f4a7c15;
  endfunction

  task automatic drive(int op, logic [127:0] s, logic [127:0] d, logic [7:0] m, logic v, logic r);
    @(posedge clk); #1;
    in_op = op[3:0]; in_src = s; in_dst = d; in_imm = m; in_valid = v; out_ready = r;
    tag = tag_of(op);
  endtask

  initial begin
    logic [7:0] imms [6] = '{8'h00, 8'hff, 8'h5a, 8'he4, 8'h1b, 8'h93};
    // R1 reset state
    tag = "R1";
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R2..R7 each code with varied immediates, streaming (R8)
    for (int op = 0; op <= 9; op++) begin
      for (int j = 0; j < 6; j++) begin
        seed = mix(seed);
        drive(op, seed, mix(seed), imms[j], 1'b1, 1'b1);
      end
    end
    drive(0, '0, '0, 8'h00, 1'b0, 1'b1);
    // R9 back-pressure: hold, then release
    for (int j = 0; j < 5; j++) begin
      seed = mix(seed);
      drive(3 + j, seed, ~seed, 8'h6c, 1'b1, 1'b0);
      tag = "R9";
    end
    drive(1, seed, seed, 8'h0f, 1'b1, 1'b1); tag = "R9";
    drive(1, seed, seed, 8'h0f, 1'b0, 1'b0); tag = "R9";
    drive(1, seed, seed, 8'h0f, 1'b0, 1'b1); tag = "R9";
    // R10 undefined codes keep data
    for (int op = 10; op <= 15; op++) begin
      seed = mix(seed);
      drive(9, seed, seed, 8'h4e, 1'b1, 1'b1);
      drive(op, mix(seed), seed, 8'hff, 1'b1, 1'b1);
      drive(op, seed, seed, 8'h00, 1'b0, 1'b1);
    end
    // R8 random mix with intermittent stalls
    for (int j = 0; j < 60; j++) begin
      seed = mix(seed);
      drive(int'(seed[3:0]) % 10, seed, mix(seed), seed[15:8], seed[20], seed[21] | seed[22]);
      tag = "R8";
    end
    drive(0, '0, '0, 8'h00, 1'b0, 1'b1);
    @(posedge clk); @(negedge clk); #1;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule